// File: doc/BRIEF.md
# Serial-Bus Link Control Register

This block is a single 32-bit control register for the link layer of a serial bus. It is accessed over a simple register bus: an address, a write enable and write data, with read data returned combinationally for the same address. Most of its bits are ordinary read/write configuration bits, and each one drives a control output directly. A few bits behave differently. Some refuse a write under a status condition. Some produce a one-cycle strobe and read back as 0. One bit can be cleared by hardware.

Status inputs feed these side effects. The transmit and receive enables lock out the acceleration bit. A cycle-too-long event clears the cycle-master bit unless the disable bit is set. An auto-cycle-master flag freezes software writes to the cycle-master bit. A local bus-reset event, qualified by an enable bit, raises a request to force the 10-bit bus number to 0x3FF.

The idle-insertion bit tells the PHY signalling logic to place one idle code (00) on the 2-bit control lines between the PHY-transmit code (10) and the link-transmit code (11). When the bit is clear, no idle code is inserted. That signalling logic is outside this block.

Top module: `link_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0048_0000: bit 22 (idle insert) and bit 19 (contender) are 1 and every other bit is 0. All strobe outputs are 0.
- R2: The plain bits (23 concatenation, 22 idle insert, 19 contender, 15 bus-number reset enable, 14 long hold, 10 cycle-too-long disable, 9 cycle timer enable) take write data on a write to the register address. They read back the written value and drive their outputs from the next cycle.
- R3: A write of 1 to bit 24 (acceleration enable) is ignored while tx_en_i and rx_en_i are both 1. A write of 0 always takes effect.
- R4: Writing 1 to bit 21 or bit 20 drives tx_reset_o or rx_reset_o, respectively, high for exactly the one cycle after the write. These bits always read 0.
- R5: Writing 1 to bit 8 drives selfid_clr_o high for exactly the one cycle after the write. Bit 8 always reads 0.
- R6: Bits 31:25, 18:16, 13:12 and 7:0 always read 0, and writes to them have no effect.
- R7: When cyc_too_long_i is 1 and bit 10 is 0, bit 11 (cycle master) is 0 in the next cycle. When bit 10 is 1, the event leaves bit 11 unchanged.
- R8: While cm_auto_i is 1, software writes to bit 11 are ignored.
- R9: If a hardware clear of bit 11 and a software write of 1 to bit 11 occur in the same cycle, the bit becomes 0.
- R10: When bus_reset_i is 1 and bit 15 is 1, bus_num_rst_o is 1 in the next cycle. Otherwise it is 0.
- R11: Reads at any other address return 0, and writes to any other address change no bit and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| tx_en_i | input | 1 | Transmitter enabled |
| rx_en_i | input | 1 | Receiver enabled |
| cyc_too_long_i | input | 1 | Cycle-too-long event |
| bus_reset_i | input | 1 | Local bus reset detected |
| cm_auto_i | input | 1 | Auto cycle-master configuration |
| accel_en_o | output | 1 | Acceleration enable |
| concat_en_o | output | 1 | Packet concatenation enable |
| idle_insert_o | output | 1 | Idle code insertion enable |
| contender_o | output | 1 | Contender pin value |
| bus_num_rst_en_o | output | 1 | Bus-number reset enable |
| long_hold_o | output | 1 | Delayed acknowledge enable |
| cyc_master_o | output | 1 | Cycle master enable |
| cyc_too_long_dis_o | output | 1 | Cycle-too-long clear disable |
| cyc_timer_en_o | output | 1 | Cycle timer enable |
| tx_reset_o | output | 1 | One-cycle transmitter reset |
| rx_reset_o | output | 1 | One-cycle receiver reset |
| selfid_clr_o | output | 1 | One-cycle self-ID error clear |
| bus_num_rst_o | output | 1 | Bus number force-to-0x3FF request |

## Verification
The collision of interest is a software write to the cycle-master bit in the same cycle as a cycle-too-long event. It is provoked with directed steps and with random stimulus in which both inputs are frequent. The result is judged on the bit's value in the next cycle, which must be 0 unless the disable bit is set. The same stimulus also covers writes that meet the auto-cycle-master flag. These are judged by the bit holding its previous value.

// File: rtl/link_ctrl_pkg.sv
package link_ctrl_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_ACCEL  = 24;
  localparam int unsigned B_CONCAT = 23;
  localparam int unsigned B_IDLE   = 22;
  localparam int unsigned B_TXRST  = 21;
  localparam int unsigned B_RXRST  = 20;
  localparam int unsigned B_CONT   = 19;
  localparam int unsigned B_BUSN   = 15;
  localparam int unsigned B_HOLD   = 14;
  localparam int unsigned B_CM     = 11;
  localparam int unsigned B_CTLDIS = 10;
  localparam int unsigned B_TMR    = 9;
  localparam int unsigned B_SIDCLR = 8;

  localparam logic [REG_W-1:0] PLAIN_MASK =
      (32'd1 << B_CONCAT) | (32'd1 << B_IDLE) | (32'd1 << B_CONT) |
      (32'd1 << B_BUSN)   | (32'd1 << B_HOLD) | (32'd1 << B_CTLDIS) |
      (32'd1 << B_TMR);
  localparam logic [REG_W-1:0] RST_VAL  = (32'd1 << B_IDLE) | (32'd1 << B_CONT);
  localparam logic [REG_W-1:0] READ_MASK = PLAIN_MASK | (32'd1 << B_ACCEL) | (32'd1 << B_CM);

  // strobe vector positions
  localparam int unsigned S_TX  = 0;
  localparam int unsigned S_RX  = 1;
  localparam int unsigned S_SID = 2;
  localparam int unsigned S_BNR = 3;
  localparam int unsigned N_STB = 4;
endpackage

// File: rtl/lcr_rw_bits.sv
module lcr_rw_bits #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '0,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_o[i] <= RSTV[i];
        else if (wr_i) q_o[i] <= wdata_i[i];
      end
    end else begin : g_zero
      assign q_o[i] = 1'b0;
    end
  end

  logic unused_wd;
  assign unused_wd = ^(wdata_i & ~MASK);
endmodule

// File: rtl/lcr_guarded_bits.sv
module lcr_guarded_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wd_accel_i,
  input  logic wd_cm_i,
  input  logic tx_en_i,
  input  logic rx_en_i,
  input  logic cm_auto_i,
  input  logic cyc_too_long_i,
  input  logic ctl_dis_i,
  output logic accel_q_o,
  output logic cm_q_o
);
  logic accel_lock, cm_hw_clr;
  assign accel_lock = tx_en_i & rx_en_i & wd_accel_i;
  assign cm_hw_clr  = cyc_too_long_i & ~ctl_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 accel_q_o <= 1'b0;
    else if (wr_i && !accel_lock) accel_q_o <= wd_accel_i;
  end

  // hardware clear has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cm_q_o <= 1'b0;
    else if (cm_hw_clr)            cm_q_o <= 1'b0;
    else if (wr_i && !cm_auto_i)   cm_q_o <= wd_cm_i;
  end
endmodule

// File: rtl/lcr_strobes.sv
module lcr_strobes #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] pulse_o
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[i] <= 1'b0;
      else         pulse_o[i] <= trig_i[i];
    end
  end
endmodule

// File: rtl/link_ctrl_reg.sv
module link_ctrl_reg
  import link_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tx_en_i,
  input  logic              rx_en_i,
  input  logic              cyc_too_long_i,
  input  logic              bus_reset_i,
  input  logic              cm_auto_i,
  output logic              accel_en_o,
  output logic              concat_en_o,
  output logic              idle_insert_o,
  output logic              contender_o,
  output logic              bus_num_rst_en_o,
  output logic              long_hold_o,
  output logic              cyc_master_o,
  output logic              cyc_too_long_dis_o,
  output logic              cyc_timer_en_o,
  output logic              tx_reset_o,
  output logic              rx_reset_o,
  output logic              selfid_clr_o,
  output logic              bus_num_rst_o
);
  logic             hit, wr;
  logic [REG_W-1:0] plain_q, image;
  logic             accel_q, cm_q;
  logic [N_STB-1:0] trig, pulse;

  assign hit = (addr_i == REG_ADDR);
  assign wr  = we_i & hit;

  lcr_rw_bits #(.W(REG_W), .MASK(PLAIN_MASK), .RSTV(RST_VAL)) u_plain (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i, .q_o(plain_q)
  );

  lcr_guarded_bits u_guard (
    .clk_i, .rst_ni,
    .wr_i          (wr),
    .wd_accel_i    (wdata_i[B_ACCEL]),
    .wd_cm_i       (wdata_i[B_CM]),
    .tx_en_i, .rx_en_i, .cm_auto_i, .cyc_too_long_i,
    .ctl_dis_i     (plain_q[B_CTLDIS]),
    .accel_q_o     (accel_q),
    .cm_q_o        (cm_q)
  );

  always_comb begin
    trig        = '0;
    trig[S_TX]  = wr & wdata_i[B_TXRST];
    trig[S_RX]  = wr & wdata_i[B_RXRST];
    trig[S_SID] = wr & wdata_i[B_SIDCLR];
    trig[S_BNR] = bus_reset_i & plain_q[B_BUSN];
  end

  lcr_strobes #(.N(N_STB)) u_stb (.clk_i, .rst_ni, .trig_i(trig), .pulse_o(pulse));

  always_comb begin
    image          = plain_q;
    image[B_ACCEL] = accel_q;
    image[B_CM]    = cm_q;
  end
  assign rdata_o = hit ? image : '0;

  assign accel_en_o         = accel_q;
  assign concat_en_o        = plain_q[B_CONCAT];
  assign idle_insert_o      = plain_q[B_IDLE];
  assign contender_o        = plain_q[B_CONT];
  assign bus_num_rst_en_o   = plain_q[B_BUSN];
  assign long_hold_o        = plain_q[B_HOLD];
  assign cyc_master_o       = cm_q;
  assign cyc_too_long_dis_o = plain_q[B_CTLDIS];
  assign cyc_timer_en_o     = plain_q[B_TMR];
  assign tx_reset_o         = pulse[S_TX];
  assign rx_reset_o         = pulse[S_RX];
  assign selfid_clr_o       = pulse[S_SID];
  assign bus_num_rst_o      = pulse[S_BNR];
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker
  import link_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              tx_en_i,
  input logic              rx_en_i,
  input logic              cyc_too_long_i,
  input logic              bus_reset_i,
  input logic              cm_auto_i,
  input logic              accel_en_o,
  input logic              cyc_master_o,
  input logic              cyc_too_long_dis_o,
  input logic              bus_num_rst_en_o,
  input logic              tx_reset_o,
  input logic              rx_reset_o,
  input logic              selfid_clr_o,
  input logic              bus_num_rst_o
);
  logic wr;
  assign wr = we_i && (addr_i == REG_ADDR);

  assert_accel_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i && rx_en_i && !accel_en_o |=> !accel_en_o);

  assert_tx_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_o |-> $past(wr && wdata_i[B_TXRST]));

  assert_rx_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_o |-> $past(wr && wdata_i[B_RXRST]));

  assert_sid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    selfid_clr_o |-> $past(wr && wdata_i[B_SIDCLR]));

  assert_rsvd_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~READ_MASK) == 32'd0);

  assert_cm_hwclr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_too_long_i && !cyc_too_long_dis_o |=> !cyc_master_o);

  assert_cm_auto_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_auto_i && !cyc_too_long_i |=> $stable(cyc_master_o));

  assert_cm_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_too_long_i && !cyc_too_long_dis_o && wr && wdata_i[B_CM] |=> !cyc_master_o);

  assert_bnr_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_num_rst_o |-> $past(bus_reset_i && bus_num_rst_en_o));

  assert_other_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != REG_ADDR) |-> rdata_o == 32'd0);
endmodule

bind link_ctrl_reg lcr_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o, .tx_en_i, .rx_en_i,
  .cyc_too_long_i, .bus_reset_i, .cm_auto_i, .accel_en_o, .cyc_master_o,
  .cyc_too_long_dis_o, .bus_num_rst_en_o, .tx_reset_o, .rx_reset_o,
  .selfid_clr_o, .bus_num_rst_o
);

// File: tb/sim_link_ctrl_reg.sv
`timescale 1ns/1ps
module sim_link_ctrl_reg;
  localparam logic [11:0] RA = 12'h010;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [11:0] addr_i = RA;
  logic we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic tx_en_i = 0, rx_en_i = 0, cyc_too_long_i = 0, bus_reset_i = 0, cm_auto_i = 0;
  logic accel_en_o, concat_en_o, idle_insert_o, contender_o, bus_num_rst_en_o, long_hold_o;
  logic cyc_master_o, cyc_too_long_dis_o, cyc_timer_en_o;
  logic tx_reset_o, rx_reset_o, selfid_clr_o, bus_num_rst_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  link_ctrl_reg #(.ADDR_W(12), .REG_ADDR(RA)) u0 (.*);

  // bench model state
  logic m_accel, m_concat, m_idle, m_cont, m_busn, m_hold, m_cm, m_ctld, m_tmr;
  logic m_tx, m_rx, m_sid, m_bnr;

  task automatic model_reset();
    {m_accel, m_concat, m_hold, m_busn, m_cm, m_ctld, m_tmr} = '0;
    {m_tx, m_rx, m_sid, m_bnr} = '0;
    m_idle = 1'b1; m_cont = 1'b1;
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] v = '0;
    if (a != RA) return 32'd0;
    v[24] = m_accel; v[23] = m_concat; v[22] = m_idle; v[19] = m_cont;
    v[15] = m_busn;  v[14] = m_hold;   v[11] = m_cm;   v[10] = m_ctld; v[9] = m_tmr;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R2", {25'd0, concat_en_o, idle_insert_o, contender_o, bus_num_rst_en_o,
               long_hold_o, cyc_too_long_dis_o, cyc_timer_en_o},
        {25'd0, m_concat, m_idle, m_cont, m_busn, m_hold, m_ctld, m_tmr});
    chk("R3", {31'd0, accel_en_o}, {31'd0, m_accel});
    chk("R7", {31'd0, cyc_master_o}, {31'd0, m_cm});
    chk("R4", {30'd0, tx_reset_o, rx_reset_o}, {30'd0, m_tx, m_rx});
    chk("R5", {31'd0, selfid_clr_o}, {31'd0, m_sid});
    chk("R10", {31'd0, bus_num_rst_o}, {31'd0, m_bnr});
  endtask

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic tx, input logic rx, input logic ctl,
                      input logic br, input logic au);
    logic hit, n_accel, n_cm;
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; tx_en_i = tx; rx_en_i = rx;
    cyc_too_long_i = ctl; bus_reset_i = br; cm_auto_i = au;
    #1;
    chk((a == RA) ? "R6" : "R11", rdata_o, exp_read(a));
    hit = we && (a == RA);
    n_accel = m_accel;
    if (hit) n_accel = (d[24] && tx && rx) ? m_accel : d[24];
    n_cm = m_cm;
    if (ctl && !m_ctld) n_cm = 1'b0;
    else if (hit && !au) n_cm = d[11];
    m_bnr = br && m_busn;
    m_tx = hit && d[21]; m_rx = hit && d[20]; m_sid = hit && d[8];
    if (hit) begin
      m_concat = d[23]; m_idle = d[22]; m_cont = d[19]; m_busn = d[15];
      m_hold = d[14]; m_ctld = d[10]; m_tmr = d[9];
    end
    m_accel = n_accel; m_cm = n_cm;
    @(posedge clk_i); #1;
    check_outputs();
  endtask

  initial begin : watchdog
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1394_5eed));
    model_reset();
    #20;
    chk("R1", rdata_o, 32'h0048_0000);
    chk("R1", {28'd0, tx_reset_o, rx_reset_o, selfid_clr_o, bus_num_rst_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_outputs();

    // R2 plain bits, R6 reserved bits written with ones
    step(1, RA, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    step(0, RA, 32'h0, 0, 0, 0, 0, 0);
    chk("R6", rdata_o & 32'hFE07_30FF, 32'd0);
    chk("R4", {31'd0, tx_reset_o}, 32'd0); // pulse lasts one cycle
    // R3: clear accel, then attempt set with both enables high
    step(1, RA, 32'h0, 0, 0, 0, 0, 0);
    step(1, RA, 32'h0100_0000, 1, 1, 0, 0, 0);
    chk("R3", {31'd0, accel_en_o}, 32'd0);
    step(1, RA, 32'h0100_0000, 1, 0, 0, 0, 0);
    chk("R3", {31'd0, accel_en_o}, 32'd1);
    // R9: set cm then collide write of 1 with hardware clear
    step(1, RA, 32'h0000_0800, 0, 0, 0, 0, 0);
    step(1, RA, 32'h0000_0800, 0, 0, 1, 0, 0);
    chk("R9", {31'd0, cyc_master_o}, 32'd0);
    // R7 with disable bit set: event leaves cm at 1
    step(1, RA, 32'h0000_0C00, 0, 0, 0, 0, 0);
    step(0, RA, 32'h0, 0, 0, 1, 0, 0);
    chk("R7", {31'd0, cyc_master_o}, 32'd1);
    // R8: auto flag blocks a clearing write
    step(1, RA, 32'h0000_0400, 0, 0, 0, 0, 1);
    chk("R8", {31'd0, cyc_master_o}, 32'd1);
    // R10 and R11: other address write ignored
    step(1, RA, 32'h0000_8000, 0, 0, 0, 0, 0);
    step(1, 12'h011, 32'h0, 0, 0, 0, 1, 0);
    chk("R10", {31'd0, bus_num_rst_o}, 32'd1);
    chk("R11", {31'd0, bus_num_rst_en_o}, 32'd1);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic both;
      a = ($urandom_range(3) != 0) ? RA : 12'($urandom);
      both = ($urandom_range(1) == 1);
      step($urandom_range(2) != 0, a, $urandom,
           both | ($urandom_range(1) == 1), both | ($urandom_range(1) == 1),
           $urandom_range(4) == 0, $urandom_range(3) == 0, $urandom_range(3) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule